// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Channel

This block is one 24-bit counter channel driven through four 16-bit word registers: two count words, a mode word and a command word. In its counting modes it follows a quadrature encoder at single, double or quadruple resolution, or it counts every system clock. It can clear itself on the rising edge of an index input, and its direction can come from the encoder phases or be forced by the mode word. In its generator modes it uses two preload values. It first waits for a delay of preload-1 clocks and then drives a pulse that lasts preload-0 clocks. It does this once, or it repeats the cycle as a pulse train.

The host writes the two preloads through the shared low/high count words. A select bit in the mode word chooses which preload those writes reach. A read of the count words returns the live counter. When the latch option is set, reading the low word freezes the high byte, so a two-word read is coherent. A command write either clears the counter or loads it. In a counting mode the load takes preload 0; in a generator mode it starts the pulse sequence.

The pulse generator is a four-state machine. GEN_IDLE leaves the output inactive. GEN_DELAY counts the delay down. GEN_ACTIVE drives the pulse. GEN_DONE is the resting state after a single pulse. The transitions are:
- start: IDLE, DONE or any other state goes to DELAY on a load command, or to ACTIVE when the delay preload is zero.
- delay_end: DELAY goes to ACTIVE.
- pulse_end: ACTIVE goes to DONE in single mode, or back to DELAY in train mode.
- abort: any state goes to IDLE on a clear command or a mode write.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count words read 0, the mode word reads 0 and `gen_out` is 0.
- R2: A read of the mode word (word address 2) returns exactly the value last written to it.
- R3: A read of word address 0 returns counter bits 15..0. A read of word address 1 returns counter bits 23..16 in bits 7..0, with bits 15..8 zero. The counter wraps modulo 2^24.
- R4: With clock source code 2 (mode bits 10..9), every legal phase change counts by one. The count goes up when phase A leads B (A,B sequence 00,10,11,01) and down in the reverse order.
- R5: With clock source code 1 the counter steps only on A edges, 2 counts per phase cycle. With code 0 it steps only on A rising edges, 1 count per cycle.
- R6: A cycle in which both synchronized phases change together does not change the counter.
- R7: With mode bit 12 set, mode bit 11 sets the direction (1 = down) regardless of the phases. Clock source code 3 counts once per system clock in the direction given by bit 11.
- R8: Command bit 15 clears the counter. Command bit 14 loads preload 0 in a counting mode. When both bits are set, the clear wins.
- R9: Mode bit 14 steers writes to word 0 (preload bits 15..0) and word 1 (bits 23..16 from data bits 7..0) into preload 1 when set, and into preload 0 when clear.
- R10: With action code 4 (mode bits 4..2), an index rising edge clears the counter, and the clear takes priority over a count step in the same cycle.
- R11: With action code 1, a load command gives a pulse that starts preload-1 clocks later and lasts preload-0 clocks. After the pulse the output stays inactive.
- R12: With action code 2, the delay/pulse cycle repeats. The load command is ignored, leaving the output and counter unchanged, unless preload 1 > preload 0 > 0.
- R13: Mode bit 1 inverts `gen_out`. Mode bit 0 selects "counter equals zero" in place of the generator's active state.
- R14: With mode bit 13 set, a read of word 1 returns the high byte captured by the most recent read of word 0. With the bit clear, the read returns the live high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 2 | Write word address (0 low, 1 high, 2 mode, 3 command) |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe, latches the high byte on a low-word read |
| bus_raddr | input | 2 | Read word address |
| bus_rdata | output | 16 | Read data, combinational |
| enc_a | input | 1 | Quadrature phase A, asynchronous |
| enc_b | input | 1 | Quadrature phase B, asynchronous |
| enc_idx | input | 1 | Index input, asynchronous |
| gen_out | output | 1 | Channel output pin |

## Verification
The index clear and a quadrature count step can land on the same clock edge. The bench brings the counter to a nonzero value, then changes phase A and raises the index in the same cycle. Both go through the same synchronizer depth, so they reach the counter together. The counter must then read 0, not the old value plus one. A second collision is a command word that carries both the clear bit and the load bit. The counter must read 0 afterwards, not preload 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W = 16;

    // Mode word, most significant field first
    typedef struct packed {
        logic       rsvd;        // 15
        logic       pre_sel;     // 14
        logic       latch_hi;    // 13
        logic       dir_force;   // 12
        logic       dir_down;    // 11
        logic [1:0] clk_src;     // 10..9
        logic [1:0] en_ctrl;     // 8..7
        logic [1:0] hw_en_src;   // 6..5
        logic [2:0] auto_act;    // 4..2
        logic       out_pol;     // 1
        logic       out_src;     // 0
    } mode_t;

    typedef enum logic [1:0] {
        GEN_IDLE   = 2'd0,
        GEN_DELAY  = 2'd1,
        GEN_ACTIVE = 2'd2,
        GEN_DONE   = 2'd3
    } gen_state_e;

    localparam logic [1:0] CLK_X1  = 2'd0;
    localparam logic [1:0] CLK_X2  = 2'd1;
    localparam logic [1:0] CLK_X4  = 2'd2;
    localparam logic [1:0] CLK_INT = 2'd3;

    localparam logic [2:0] ACT_NONE   = 3'd0;
    localparam logic [2:0] ACT_SINGLE = 3'd1;
    localparam logic [2:0] ACT_TRAIN  = 3'd2;
    localparam logic [2:0] ACT_INDEX  = 3'd4;

    localparam logic [1:0] WA_LO   = 2'd0;
    localparam logic [1:0] WA_HI   = 2'd1;
    localparam logic [1:0] WA_MODE = 2'd2;
    localparam logic [1:0] WA_CMD  = 2'd3;

    localparam int CMD_CLR_BIT  = 15;
    localparam int CMD_LOAD_BIT = 14;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a_in,
    input  logic       b_in,
    input  logic       idx_in,
    input  logic [1:0] clk_src,
    output logic       step,
    output logic       step_up,
    output logic       idx_rise
);

    logic [SYNC_STAGES-1:0] a_sh, b_sh, i_sh;
    logic a_p, b_p, i_p;
    logic a_s, b_s, i_s;
    logic a_chg, b_chg, legal;

    assign a_s = a_sh[SYNC_STAGES-1];
    assign b_s = b_sh[SYNC_STAGES-1];
    assign i_s = i_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sh <= '0;
            b_sh <= '0;
            i_sh <= '0;
            a_p  <= 1'b0;
            b_p  <= 1'b0;
            i_p  <= 1'b0;
        end else begin
            a_sh <= {a_sh[SYNC_STAGES-2:0], a_in};
            b_sh <= {b_sh[SYNC_STAGES-2:0], b_in};
            i_sh <= {i_sh[SYNC_STAGES-2:0], idx_in};
            a_p  <= a_s;
            b_p  <= b_s;
            i_p  <= i_s;
        end
    end

    assign a_chg    = a_s ^ a_p;
    assign b_chg    = b_s ^ b_p;
    assign legal    = a_chg ^ b_chg;   // exactly one phase moved
    assign idx_rise = i_s & ~i_p;

    always_comb begin
        step    = 1'b0;
        step_up = a_s ^ b_p;
        unique case (clk_src)
            CLK_X1:  step = legal & a_chg & a_s;
            CLK_X2:  step = legal & a_chg;
            CLK_X4:  step = legal;
            CLK_INT: begin
                step    = 1'b1;
                step_up = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] rd_data,
    output mode_t             mode_q,
    output logic [CNT_W-1:0]  pre0,
    output logic [CNT_W-1:0]  pre1,
    output logic              cmd_clr,
    output logic              cmd_load,
    output logic              mode_wr
);

    localparam int HI_W = CNT_W - DATA_W;

    logic [CNT_W-1:0] pre_q [2];
    logic [HI_W-1:0]  hold_hi;
    logic [HI_W-1:0]  hi_view;

    assign mode_wr  = wr_en && (wr_addr == WA_MODE);
    assign cmd_clr  = wr_en && (wr_addr == WA_CMD) && wr_data[CMD_CLR_BIT];
    assign cmd_load = wr_en && (wr_addr == WA_CMD) && wr_data[CMD_LOAD_BIT];
    assign pre0     = pre_q[0];
    assign pre1     = pre_q[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_t'(wr_data);
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_pre
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[g] <= '0;
            end else if (wr_en && (mode_q.pre_sel == g[0])) begin
                if (wr_addr == WA_LO)
                    pre_q[g][DATA_W-1:0] <= wr_data;
                else if (wr_addr == WA_HI)
                    pre_q[g][CNT_W-1:DATA_W] <= wr_data[HI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_hi <= '0;
        end else if (rd_en && (rd_addr == WA_LO)) begin
            hold_hi <= cnt[CNT_W-1:DATA_W];
        end
    end

    assign hi_view = mode_q.latch_hi ? hold_hi : cnt[CNT_W-1:DATA_W];

    always_comb begin
        unique case (rd_addr)
            WA_LO:   rd_data = cnt[DATA_W-1:0];
            WA_HI:   rd_data = {{(DATA_W-HI_W){1'b0}}, hi_view};
            WA_MODE: rd_data = mode_q;
            WA_CMD:  rd_data = '0;
        endcase
    end

    assert_mode_rb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_q == $past(wr_data)));

    assert_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == WA_LO) |=> (hold_hi == $past(cnt[CNT_W-1:DATA_W])));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       auto_act,
    input  logic [1:0]       clk_src,
    input  logic             dir_force,
    input  logic             dir_down,
    input  logic             out_src,
    input  logic             out_pol,
    input  logic [CNT_W-1:0] pre0,
    input  logic [CNT_W-1:0] pre1,
    input  logic             cmd_clr,
    input  logic             cmd_load,
    input  logic             mode_wr,
    input  logic             step,
    input  logic             step_up,
    input  logic             idx_rise,
    output logic [CNT_W-1:0] cnt,
    output logic             out_pin
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    gen_state_e       st, st_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             is_single, is_train, is_pulse, train_ok, go_down, idx_clr;

    assign is_single = (auto_act == ACT_SINGLE);
    assign is_train  = (auto_act == ACT_TRAIN);
    assign is_pulse  = is_single | is_train;
    assign train_ok  = (pre1 > pre0) && (pre0 != '0);
    assign go_down   = (dir_force || clk_src == CLK_INT) ? dir_down : ~step_up;
    assign idx_clr   = (auto_act == ACT_INDEX) && idx_rise;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= GEN_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // Next state and counter
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (cmd_clr) begin
            st_nx  = GEN_IDLE;
            cnt_nx = '0;
        end else if (cmd_load) begin
            if (!is_pulse) begin
                cnt_nx = pre0;
            end else if (is_single) begin
                if (pre1 != '0) begin
                    st_nx  = GEN_DELAY;
                    cnt_nx = pre1;
                end else if (pre0 != '0) begin
                    st_nx  = GEN_ACTIVE;
                    cnt_nx = pre0;
                end else begin
                    st_nx  = GEN_DONE;
                    cnt_nx = '0;
                end
            end else if (train_ok) begin
                st_nx  = GEN_DELAY;
                cnt_nx = pre1;
            end
        end else if (is_pulse) begin
            unique case (st)
                GEN_IDLE, GEN_DONE: ;
                GEN_DELAY: begin
                    if (cnt <= ONE) begin
                        if (pre0 != '0) begin
                            st_nx  = GEN_ACTIVE;
                            cnt_nx = pre0;
                        end else begin
                            st_nx  = GEN_DONE;
                            cnt_nx = '0;
                        end
                    end else begin
                        cnt_nx = cnt - ONE;
                    end
                end
                GEN_ACTIVE: begin
                    if (cnt <= ONE) begin
                        if (is_train) begin
                            st_nx  = GEN_DELAY;
                            cnt_nx = pre1;
                        end else begin
                            st_nx  = GEN_DONE;
                            cnt_nx = '0;
                        end
                    end else begin
                        cnt_nx = cnt - ONE;
                    end
                end
            endcase
        end else if (idx_clr) begin
            cnt_nx = '0;
        end else if (step) begin
            cnt_nx = go_down ? cnt - ONE : cnt + ONE;
        end
        if (mode_wr && !cmd_clr) begin
            st_nx = GEN_IDLE;
        end
    end

    // Outputs
    always_comb begin
        logic raw;
        raw     = out_src ? (cnt == '0) : (st == GEN_ACTIVE);
        out_pin = raw ^ out_pol;
    end

    assert_clr_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr |=> (cnt == '0 && st == GEN_IDLE));

    assert_idx_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_clr && !cmd_load && !is_pulse && idx_clr && step) |=> (cnt == '0));

    assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_clr && !cmd_load && !is_pulse && !idx_clr && step && !go_down)
            |=> (cnt == $past(cnt) + ONE));

    assert_single_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_clr && !cmd_load && !mode_wr && is_single && st == GEN_ACTIVE && cnt == ONE)
            |=> (st == GEN_DONE));

    assert_train_loop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_clr && !cmd_load && !mode_wr && is_train && st == GEN_ACTIVE && cnt == ONE)
            |=> (st == GEN_DELAY));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [1:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_idx,
    output logic              gen_out
);

    mode_t            mode_q;
    logic [CNT_W-1:0] cnt, pre0, pre1;
    logic             cmd_clr, cmd_load, mode_wr;
    logic             step, step_up, idx_rise;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (bus_waddr),
        .wr_data  (bus_wdata),
        .rd_en    (bus_rd),
        .rd_addr  (bus_raddr),
        .cnt      (cnt),
        .rd_data  (bus_rdata),
        .mode_q   (mode_q),
        .pre0     (pre0),
        .pre1     (pre1),
        .cmd_clr  (cmd_clr),
        .cmd_load (cmd_load),
        .mode_wr  (mode_wr)
    );

    tmr_decode #(.SYNC_STAGES(SYNC_STAGES)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (enc_a),
        .b_in     (enc_b),
        .idx_in   (enc_idx),
        .clk_src  (mode_q.clk_src),
        .step     (step),
        .step_up  (step_up),
        .idx_rise (idx_rise)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_act  (mode_q.auto_act),
        .clk_src   (mode_q.clk_src),
        .dir_force (mode_q.dir_force),
        .dir_down  (mode_q.dir_down),
        .out_src   (mode_q.out_src),
        .out_pol   (mode_q.out_pol),
        .pre0      (pre0),
        .pre1      (pre1),
        .cmd_clr   (cmd_clr),
        .cmd_load  (cmd_load),
        .mode_wr   (mode_wr),
        .step      (step),
        .step_up   (step_up),
        .idx_rise  (idx_rise),
        .cnt       (cnt),
        .out_pin   (gen_out)
    );

endmodule

// File: tb/tmr_chan_tb.sv
module tmr_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_waddr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_raddr = 2'd0;
    logic [15:0] bus_rdata;
    logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
    logic        gen_out;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;

    always #10 clk = ~clk;

    tmr_chan u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .gen_out(gen_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_raddr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic rd_cnt(output logic [31:0] v);
        logic [15:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set_phase();
        enc_a = (ph == 1 || ph == 2);
        enc_b = (ph == 2 || ph == 3);
    endtask

    task automatic quad(input int n, input bit fwd);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
            set_phase();
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v; logic [15:0] m;
        rd_cnt(v);           chk("R1 count", v, 0);
        rd(2'd2, m);         chk("R1 mode", {16'd0, m}, 0);
        chk("R1 out", {31'd0, gen_out}, 0);
    endtask

    task automatic t_mode_rb();
        logic [15:0] m;
        wr(2'd2, 16'hA5C3);
        rd(2'd2, m);         chk("R2 readback", {16'd0, m}, 32'hA5C3);
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h8000);
    endtask

    task automatic t_x4();
        logic [31:0] v;
        wr(2'd2, 16'h0400);
        quad(8, 1'b1);
        rd_cnt(v);           chk("R4 x4 up", v, 8);
        quad(3, 1'b0);
        rd_cnt(v);           chk("R4 x4 down", v, 5);
    endtask

    task automatic t_x2_x1();
        logic [31:0] v;
        wr(2'd3, 16'h8000);
        wr(2'd2, 16'h0200);
        quad(4, 1'b1);
        rd_cnt(v);           chk("R5 x2", v, 2);
        wr(2'd2, 16'h0000);
        quad(4, 1'b1);
        rd_cnt(v);           chk("R5 x1 up", v, 3);
        quad(4, 1'b0);
        rd_cnt(v);           chk("R5 x1 down", v, 2);
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        wr(2'd2, 16'h0400);
        @(negedge clk);
        ph = (ph + 2) % 4;
        set_phase();
        repeat (5) @(negedge clk);
        rd_cnt(v);           chk("R6 double change", v, 2);
    endtask

    task automatic t_force();
        logic [31:0] v;
        wr(2'd3, 16'h8000);
        wr(2'd2, 16'h1C00);
        quad(4, 1'b1);
        rd_cnt(v);           chk("R7 forced down / R3 wrap", v, 32'h00FF_FFFC);
        wr(2'd3, 16'h8000);
        wr(2'd2, 16'h0600);
        repeat (9) @(posedge clk);
        wr(2'd2, 16'h0000);
        rd_cnt(v);           chk("R7 internal up", v, 10);
        wr(2'd2, 16'h0E00);
        repeat (2) @(posedge clk);
        wr(2'd2, 16'h0000);
        rd_cnt(v);           chk("R7 internal down", v, 7);
    endtask

    task automatic t_preload();
        logic [31:0] v;
        wr(2'd2, 16'h4000);
        wr(2'd0, 16'h1111);
        wr(2'd1, 16'h0022);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'hBEEF);
        wr(2'd1, 16'hFF12);
        wr(2'd3, 16'h4000);
        rd_cnt(v);           chk("R9 load preload0 / R3 split", v, 32'h0012_BEEF);
        wr(2'd3, 16'hC000);
        rd_cnt(v);           chk("R8 clear wins", v, 0);
        wr(2'd3, 16'h4000);
        wr(2'd3, 16'h8000);
        rd_cnt(v);           chk("R8 clear", v, 0);
    endtask

    task automatic t_index();
        logic [31:0] v;
        wr(2'd2, 16'h0410);
        quad(3, 1'b1);
        rd_cnt(v);           chk("R10 before index", v, 3);
        @(negedge clk); enc_idx = 1'b1;
        repeat (5) @(negedge clk);
        rd_cnt(v);           chk("R10 index clear", v, 0);
        enc_idx = 1'b0;
        quad(2, 1'b1);
        rd_cnt(v);           chk("R10 fall ignored", v, 2);
        @(negedge clk);
        ph = (ph + 1) % 4; set_phase(); enc_idx = 1'b1;
        repeat (5) @(negedge clk);
        rd_cnt(v);           chk("R10 index beats step", v, 0);
        enc_idx = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_pre(input logic [15:0] p0, input logic [15:0] p1, input logic [15:0] md);
        wr(2'd2, md | 16'h4000);
        wr(2'd0, p1); wr(2'd1, 16'h0000);
        wr(2'd2, md);
        wr(2'd0, p0); wr(2'd1, 16'h0000);
    endtask

    task automatic t_single();
        int bad = 0;
        set_pre(16'd3, 16'd4, 16'h0004);
        wr(2'd3, 16'h4000);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (gen_out !== ((i >= 4 && i < 7) ? 1'b1 : 1'b0)) begin
                bad++;
                $display("FAIL R11 sample %0d: got %0b expected %0b", i, gen_out, (i >= 4 && i < 7));
            end
        end
        n_chk++; if (bad != 0) n_bad++;
    endtask

    task automatic t_train();
        int bad = 0;
        logic [31:0] v1, v2;
        set_pre(16'd2, 16'd3, 16'h0008);
        wr(2'd3, 16'h4000);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (gen_out !== (((i % 5) >= 3) ? 1'b1 : 1'b0)) begin
                bad++;
                $display("FAIL R12 sample %0d: got %0b expected %0b", i, gen_out, ((i % 5) >= 3));
            end
        end
        n_chk++; if (bad != 0) n_bad++;
        set_pre(16'd3, 16'd3, 16'h0008);
        rd_cnt(v1);
        wr(2'd3, 16'h4000);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (gen_out !== 1'b0) bad++;
        end
        chk("R12 invalid params out", bad, 0);
        rd_cnt(v2);          chk("R12 invalid params count", v2, v1);
    endtask

    task automatic t_out_sel();
        wr(2'd2, 16'h0006);
        @(negedge clk);      chk("R13 inverted idle", {31'd0, gen_out}, 1);
        wr(2'd3, 16'h8000);
        wr(2'd2, 16'h0001);
        @(negedge clk);      chk("R13 zero flag", {31'd0, gen_out}, 1);
        wr(2'd0, 16'h0009);
        wr(2'd1, 16'h0000);
        wr(2'd3, 16'h4000);
        @(negedge clk);      chk("R13 zero flag off", {31'd0, gen_out}, 0);
    endtask

    task automatic t_latch();
        logic [15:0] lo, hi;
        wr(2'd2, 16'h2000);
        wr(2'd0, 16'h0001); wr(2'd1, 16'h0005);
        wr(2'd3, 16'h4000);
        rd(2'd0, lo);
        wr(2'd1, 16'h0007);
        wr(2'd3, 16'h4000);
        rd(2'd1, hi);        chk("R14 latched high", {16'd0, hi}, 5);
        rd(2'd0, lo);
        rd(2'd1, hi);        chk("R14 relatched high", {16'd0, hi}, 7);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0009);
        wr(2'd3, 16'h4000);
        rd(2'd1, hi);        chk("R14 live high", {16'd0, hi}, 9);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_mode_rb();
        t_x4();
        t_x2_x1();
        t_illegal();
        t_force();
        t_preload();
        t_index();
        t_single();
        t_train();
        t_out_sel();
        t_latch();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule